// File: doc/BRIEF.md
# GPIO Pin Input Conditioning and Interrupt Slice

This block is the logic behind one general-purpose I/O pin. It holds a single configuration register that software writes and reads back. The incoming pad level passes through two synchronizer stages in series, and each stage can be bypassed or can sample on either clock edge. The conditioned level then drives an interrupt detector. The detector is set by a 3-bit type code that selects no interrupt, a rising, falling or either-edge trigger, or an active-low or active-high level.

An edge event is held in a pending bit until software clears it by pulsing the clear input. A level condition follows the conditioned input and is not held. The active condition goes out on two separate request lines: a maskable CPU interrupt and a non-maskable CPU interrupt, each with its own enable bit. The same condition raises a wakeup request, but only while the light-sleep input is high and wakeup is enabled. On the output side, one drive-mode bit chooses between push-pull drive and open-drain drive. In open-drain drive the pin pulls only low and floats when the output is high.

Top module: `gpio_pin_slice`

## Requirements
- R1: After reset the configuration reads 0. On a clock edge with `cfg_we` high, bits [10:0] of `cfg_wdata` are stored. `cfg_rdata` returns the stored bits in [10:0] and zero in [15:11] from the next cycle on.
- R2: With type code `cfg[2:0]` set to 1 (rising), 2 (falling) or 3 (either), a matching change of the conditioned input between two clocks sets `int_pending` at that clock edge. The bit stays set until a clock edge on which `stat_clr` is high and no new event arrives. If an event and a clear arrive on the same edge, the bit stays set.
- R3: Type code 4 makes the condition equal to the inverted conditioned input, and type code 5 makes it equal to the conditioned input. Neither code latches anything.
- R4: Type codes 0, 6 and 7 never raise `irq`, `nmi` or `wake`, whatever the input does.
- R5: `irq` is the condition gated by `cfg[3]`, and `nmi` is the condition gated by `cfg[4]`. The two enables act independently of each other.
- R6: When `cfg[5]` is 0 the pin drives push-pull: `pad_oe = out_en` and `pad_out = out_val`. When `cfg[5]` is 1 the pin drives open-drain: `pad_out = 0` and `pad_oe = out_en & ~out_val`.
- R7: Stage 1 mode `cfg[7:6]` selects the stage output. Code 0 passes `pad_in` straight through, code 1 uses a copy sampled on the falling clock edge, and codes 2 and 3 use a copy sampled on the rising clock edge.
- R8: Stage 2 mode `cfg[9:8]` uses the same encoding as stage 1. Its input is the output of stage 1, and its output is the conditioned input.
- R9: `wake` is the condition ANDed with `cfg[10]` and with `light_sleep`. It does not depend on `cfg[3]` or `cfg[4]`.
- R10: Choosing an edge type while the input holds a steady level sets no pending bit. Right after reset, no pending bit is set either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | configuration write strobe |
| cfg_wdata | input | 16 | configuration write data |
| cfg_rdata | output | 16 | configuration readback |
| stat_clr | input | 1 | clears the pending edge bit when high |
| pad_in | input | 1 | raw pad input level |
| out_val | input | 1 | output value from the core |
| out_en | input | 1 | output enable from the core |
| pad_out | output | 1 | value driven toward the pad |
| pad_oe | output | 1 | pad driver enable |
| light_sleep | input | 1 | system is in light sleep |
| int_pending | output | 1 | latched edge event |
| irq | output | 1 | maskable interrupt request |
| nmi | output | 1 | non-maskable interrupt request |
| wake | output | 1 | wakeup request |

## Verification
The pad drive outputs, and a level condition with both stages bypassed, change in the same cycle as their inputs. Each stage that samples on the rising edge adds one clock of delay. A stage that samples on the falling edge adds half a clock. An edge event shows up on `int_pending` at the first rising edge after the conditioned input changes, and a configuration write shows up one clock after the strobe. Inputs change 5 ns after a rising edge. The bench keeps its own model of both sampling edges and checks every output 18 ns after each rising edge, so each delay above has already taken effect when a check is made.

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        stat_clr,
  input  logic        pad_in,
  input  logic        out_val,
  input  logic        out_en,
  output logic        pad_out,
  output logic        pad_oe,
  input  logic        light_sleep,
  output logic        int_pending,
  output logic        irq,
  output logic        nmi,
  output logic        wake
);
  localparam int CFG_W = 11;

  logic [CFG_W-1:0] cfg;
  logic [2:0] itype;
  logic [1:0] m1, m2;
  logic s1_p, s1_n, s2_p, s2_n, st1, cin, prev, hit, cond;

  assign itype = cfg[2:0];
  assign m1    = cfg[7:6];
  assign m2    = cfg[9:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= '0;
    else if (cfg_we) cfg <= cfg_wdata[CFG_W-1:0];

  assign cfg_rdata = {{(16-CFG_W){1'b0}}, cfg};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_p <= 1'b0;
      s2_p <= 1'b0;
    end else begin
      s1_p <= pad_in;
      s2_p <= st1;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_n <= 1'b0;
      s2_n <= 1'b0;
    end else begin
      s1_n <= pad_in;
      s2_n <= st1;
    end

  assign st1 = (m1 == 2'd0) ? pad_in : (m1 == 2'd1) ? s1_n : s1_p;
  assign cin = (m2 == 2'd0) ? st1    : (m2 == 2'd1) ? s2_n : s2_p;

  always_comb
    case (itype)
      3'd1:    hit = cin & ~prev;
      3'd2:    hit = ~cin & prev;
      3'd3:    hit = cin ^ prev;
      default: hit = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev        <= 1'b0;
      int_pending <= 1'b0;
    end else begin
      prev        <= cin;
      int_pending <= (int_pending & ~stat_clr) | hit;
    end

  always_comb
    case (itype)
      3'd1, 3'd2, 3'd3: cond = int_pending;
      3'd4:             cond = ~cin;
      3'd5:             cond = cin;
      default:          cond = 1'b0;
    endcase

  assign irq     = cond & cfg[3];
  assign nmi     = cond & cfg[4];
  assign wake    = cond & cfg[10] & light_sleep;
  assign pad_out = cfg[5] ? 1'b0 : out_val;
  assign pad_oe  = out_en & ~(cfg[5] & out_val);
endmodule

module gpio_pin_slice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rdata,
  input logic        cfg_we,
  input logic        stat_clr,
  input logic        light_sleep,
  input logic        int_pending,
  input logic        irq,
  input logic        nmi,
  input logic        wake,
  input logic        pad_out,
  input logic        pad_oe,
  input logic        out_en
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else seen <= 1'b1;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:11] == 5'd0);
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  assert_pending_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && !stat_clr) |=> int_pending);
  assert_type_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2:0] == 3'd0 || cfg_rdata[2:0] > 3'd5) |-> !(irq || nmi || wake));
  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[3] |-> !irq) and (!cfg_rdata[4] |-> !nmi));
  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] |-> (!pad_out && (!pad_oe || out_en)));
  assert_wake_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!light_sleep || !cfg_rdata[10]) |-> !wake);
  assert_no_reset_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |=> !int_pending);
endmodule

bind gpio_pin_slice gpio_pin_slice_chk chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .cfg_we(cfg_we),
  .stat_clr(stat_clr), .light_sleep(light_sleep), .int_pending(int_pending),
  .irq(irq), .nmi(nmi), .wake(wake), .pad_out(pad_out), .pad_oe(pad_oe),
  .out_en(out_en)
);

// File: tb/gpio_pin_slice_test.sv
`timescale 1ns/1ps
module gpio_pin_slice_test;
  logic clk = 0, rst_n = 0, cfg_we = 0, stat_clr = 0, pad_in = 0;
  logic out_val = 0, out_en = 0, light_sleep = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic pad_out, pad_oe, int_pending, irq, nmi, wake;
  int total = 0, bad = 0;
  string req = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_pin_slice uut (.*);

  // reference model state
  int mcfg, mstat, mprev, f1, f2, r1, r2;

  function automatic int fld(int v, int lo, int n);
    return (v >> lo) % (1 << n);
  endfunction
  function automatic int stage(int mode, int raw, int fv, int rv);
    if (mode == 0) return raw;
    if (mode == 1) return fv;
    return rv;
  endfunction
  function automatic int m_st1();
    return stage(fld(mcfg, 6, 2), int'(pad_in), f1, r1);
  endfunction
  function automatic int m_cin();
    return stage(fld(mcfg, 8, 2), m_st1(), f2, r2);
  endfunction
  function automatic int m_cond();
    int t = fld(mcfg, 0, 3);
    if (t >= 1 && t <= 3) return mstat;
    if (t == 4) return 1 - m_cin();
    if (t == 5) return m_cin();
    return 0;
  endfunction

  always @(negedge clk or negedge rst_n)
    if (!rst_n) begin f1 = 0; f2 = 0; end
    else begin
      int t;
      t = m_st1();
      f1 = int'(pad_in);
      f2 = t;
    end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin mcfg = 0; mstat = 0; mprev = 0; r1 = 0; r2 = 0; end
    else begin
      int c, s, t, ev;
      c = m_cin(); s = m_st1(); t = fld(mcfg, 0, 3);
      ev = 0;
      if ((t == 1 || t == 3) && c == 1 && mprev == 0) ev = 1;
      if ((t == 2 || t == 3) && c == 0 && mprev == 1) ev = 1;
      mstat = (mstat == 1 && !stat_clr) || ev == 1 ? 1 : 0;
      mprev = c;
      r1 = int'(pad_in); r2 = s;
      if (cfg_we) mcfg = int'(cfg_wdata) % 2048;
    end

  task automatic chk1(string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #18;
    if (!finished) begin
      int cd;
      cd = m_cond();
      chk1("cfg_rdata", int'(cfg_rdata), mcfg);
      chk1("int_pending", int'(int_pending), mstat);
      chk1("irq", int'(irq), cd & fld(mcfg, 3, 1));
      chk1("nmi", int'(nmi), cd & fld(mcfg, 4, 1));
      chk1("wake", int'(wake), cd & fld(mcfg, 10, 1) & int'(light_sleep));
      if (fld(mcfg, 5, 1) == 1) begin
        chk1("pad_out", int'(pad_out), 0);
        chk1("pad_oe", int'(pad_oe), int'(out_en & ~out_val));
      end else begin
        chk1("pad_out", int'(pad_out), int'(out_val));
        chk1("pad_oe", int'(pad_oe), int'(out_en));
      end
    end
  end

  function automatic logic [15:0] mk(int t, int im, int nm, int od, int s1, int s2, int we);
    return 16'(t + im*8 + nm*16 + od*32 + s1*64 + s2*256 + we*1024);
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask
  task automatic wcfg(logic [15:0] v);
    cfg_we = 1; cfg_wdata = v;
    step(1);
    cfg_we = 0;
  endtask
  task automatic wiggle(logic [7:0] pat);
    for (int i = 0; i < 8; i++) begin
      pad_in = pat[i];
      step(1);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: input high through reset, then select an edge mode at once
    pad_in = 1;
    #45; rst_n = 1;
    @(posedge clk); #5;
    req = "R10";
    wcfg(mk(1, 1, 1, 0, 0, 0, 0));
    step(3);
    // R1: readback masks upper bits
    req = "R1";
    wcfg(16'hFFFF);
    step(1);
    wcfg(16'h0155);
    step(1);
    wcfg(16'h0000);
    // R7 / R8: stage modes observed through the high-level condition
    for (int s1 = 0; s1 < 4; s1++)
      for (int s2 = 0; s2 < 4; s2++) begin
        req = (s2 == 0) ? "R7" : "R8";
        wcfg(mk(5, 1, 0, 0, s1, s2, 0));
        wiggle(8'b1011_0010);
      end
    // R3: level modes
    req = "R3";
    wcfg(mk(4, 1, 1, 0, 0, 0, 0));
    wiggle(8'b0110_1001);
    wcfg(mk(5, 1, 1, 0, 2, 0, 0));
    wiggle(8'b1100_1010);
    // R2: edge modes, clear, clear colliding with a new event
    req = "R2";
    for (int t = 1; t <= 3; t++) begin
      wcfg(mk(t, 1, 0, 0, 0, 0, 0));
      wiggle(8'b0011_0100);
      stat_clr = 1; step(1); stat_clr = 0;
      step(1);
      pad_in = ~pad_in; stat_clr = 1; step(1); stat_clr = 0;
      step(2);
      stat_clr = 1; step(1); stat_clr = 0;
    end
    // R4: disabled codes with everything else enabled
    req = "R4";
    light_sleep = 1;
    wcfg(mk(0, 1, 1, 0, 0, 0, 1));
    wiggle(8'b0101_1010);
    wcfg(mk(6, 1, 1, 0, 0, 0, 1));
    wiggle(8'b0110_0110);
    wcfg(mk(7, 1, 1, 0, 0, 0, 1));
    wiggle(8'b1001_1100);
    // R5: enable combinations with the condition active
    req = "R5";
    pad_in = 1;
    for (int e = 0; e < 4; e++) begin
      wcfg(mk(5, e % 2, e / 2, 0, 0, 0, 0));
      step(1);
    end
    // R9: wakeup only in light sleep, independent of the enables
    req = "R9";
    wcfg(mk(5, 0, 0, 0, 0, 0, 1));
    light_sleep = 0; step(2);
    light_sleep = 1; step(2);
    pad_in = 0; step(2);
    wcfg(mk(2, 0, 0, 0, 0, 0, 1));
    pad_in = 1; step(1); pad_in = 0; step(2);
    light_sleep = 0; step(1);
    stat_clr = 1; step(1); stat_clr = 0;
    // R6: drive modes
    req = "R6";
    for (int od = 0; od < 2; od++) begin
      wcfg(mk(0, 0, 0, od, 0, 0, 0));
      for (int k = 0; k < 4; k++) begin
        out_en = k[1]; out_val = k[0];
        step(1);
      end
    end
    step(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule